// File: doc/BRIEF.md
# Cache Control Register with Interrupt Freeze

This block keeps the operating state of an instruction cache and a data cache in one small control register, reachable over a simple register bus. Each cache has a 2-bit state field (disabled, frozen, enabled), plus its own enable bit that arms freezing on interrupt. The current state of both caches is driven straight to the cache controllers.

When the processor acknowledges an interrupt, a one-cycle acknowledge pulse enters the block. Every cache whose freeze bit is set and whose state is enabled moves to frozen. Nothing else changes. If software wants the cache back in service, it writes the register again, because the block has no automatic unfreeze.

Top module: `cache_ctl_reg`

## Requirements
- R1: After a synchronous active-low reset, the register reads as all zeros. Both cache state outputs are 00 (disabled).
- R2: A bus write with write enable set stores wdata[5:0] in the register. The value is visible on rdata and on the state outputs from the next cycle. rdata bits above 5 always read as zero.
- R3: Field layout: instruction cache state is [1:0] and data cache state is [3:2]. The instruction freeze enable is bit 4 and the data freeze enable is bit 5. The state encoding is 00 disabled, 01 frozen, 11 enabled; 10 behaves as disabled.
- R4: On an acknowledge pulse with bit 4 set, an instruction cache state of 11 becomes 01 on the next cycle.
- R5: On an acknowledge pulse with bit 5 set, a data cache state of 11 becomes 01 on the next cycle.
- R6: An acknowledge leaves a cache state unchanged if that cache's freeze enable is clear, or if its state is not 11.
- R7: An acknowledge never changes bits 4 and 5.
- R8: When a write and an acknowledge fall in the same cycle, the freeze rule applies to the newly written value.
- R9: The state outputs always equal the register's state fields, and a decoded 10 is presented as 00 on the state outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Register read value |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| icache_state | output | 2 | Instruction cache state to controller |
| dcache_state | output | 2 | Data cache state to controller |

## Verification
A bus write and an interrupt acknowledge can arrive in the same cycle. The bench provokes this by raising bus_we and irq_ack together, with write values that enable a cache and arm its freeze bit, and with values that leave the freeze bit disarmed. It judges the outcome by reading the register on the next cycle and expecting the frozen code only where the written value was enabled and armed.

// File: rtl/cache_ctl_pkg.sv
// Package: field positions and state codes shared by the cache control register.
package cache_ctl_pkg;
    localparam int STATE_W = 2;
    localparam int REG_W   = 6;
    localparam int I_LSB   = 0;
    localparam int D_LSB   = 2;
    localparam int I_FRZ   = 4;
    localparam int D_FRZ   = 5;

    typedef enum logic [STATE_W-1:0] {
        CST_OFF    = 2'b00,
        CST_FROZEN = 2'b01,
        CST_RSVD   = 2'b10,
        CST_ON     = 2'b11
    } cst_e;
endpackage

// File: rtl/cache_freeze_lane.sv
// Module: cache_freeze_lane
// Computes the next state for one cache. An armed acknowledge turns enabled
// into frozen. Assumes the input state is already the post-write value.
module cache_freeze_lane
    import cache_ctl_pkg::*;
(
    input  logic [STATE_W-1:0] cur_state,
    input  logic               arm,
    input  logic               ack,
    output logic [STATE_W-1:0] nxt_state
);
    // Freeze decision for one lane
    always_comb begin
        nxt_state = cur_state;
        if (ack && arm && cur_state == CST_ON)
            nxt_state = CST_FROZEN;
    end
endmodule

// File: rtl/cache_state_view.sv
// Module: cache_state_view
// Maps a stored state field to the code given to a cache controller.
// Assumes the reserved code behaves as disabled.
module cache_state_view
    import cache_ctl_pkg::*;
(
    input  logic [STATE_W-1:0] raw,
    output logic [STATE_W-1:0] shown
);
    // Fold reserved code onto disabled
    always_comb shown = (raw == CST_RSVD) ? CST_OFF : raw;
endmodule

// File: rtl/cache_ctl_reg.sv
// Module: cache_ctl_reg
// Control register holding two cache state fields and two freeze-on-interrupt
// enables. An interrupt acknowledge freezes each armed, enabled cache.
// Assumes irq_ack is a single-cycle pulse. Write and ack in the same cycle:
// the freeze acts on the written value.
module cache_ctl_reg
    import cache_ctl_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             irq_ack,
    output logic [1:0]       icache_state,
    output logic [1:0]       dcache_state
);
    localparam int NLANE = 2;

    logic [REG_W-1:0]   ctl_q;
    logic [REG_W-1:0]   base;
    logic [REG_W-1:0]   ctl_d;
    logic [STATE_W-1:0] lane_nxt [NLANE];
    logic [STATE_W-1:0] lane_out [NLANE];

    // Select the pre-freeze value: new write data or the held value
    always_comb base = bus_we ? bus_wdata[REG_W-1:0] : ctl_q;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LSB = (g == 0) ? I_LSB : D_LSB;
        localparam int FRZ = (g == 0) ? I_FRZ : D_FRZ;
        cache_freeze_lane u_lane (
            .cur_state (base[LSB +: STATE_W]),
            .arm       (base[FRZ]),
            .ack       (irq_ack),
            .nxt_state (lane_nxt[g])
        );
        cache_state_view u_view (
            .raw   (ctl_q[LSB +: STATE_W]),
            .shown (lane_out[g])
        );
    end

    // Assemble the next register value
    always_comb ctl_d = {base[D_FRZ], base[I_FRZ], lane_nxt[1], lane_nxt[0]};

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Read path and controller outputs
    always_comb begin
        bus_rdata = '0;
        bus_rdata[REG_W-1:0] = ctl_q;
        icache_state = lane_out[0];
        dcache_state = lane_out[1];
    end
endmodule

// Checker: port-level rules of the cache control register.
module cache_ctl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq_ack,
    input logic [1:0]  icache_state,
    input logic [1:0]  dcache_state
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) !rst_n |=> bus_rdata == 32'd0);
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_rdata[31:6] == 26'd0);
    // R4
    ifreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !bus_we && bus_rdata[4] && bus_rdata[1:0] == 2'b11) |=> bus_rdata[1:0] == 2'b01);
    // R5
    dfreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !bus_we && bus_rdata[5] && bus_rdata[3:2] == 2'b11) |=> bus_rdata[3:2] == 2'b01);
    // R7
    arm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !bus_we) |=> $stable(bus_rdata[5:4]));
    // R8
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && bus_we && bus_wdata[4] && bus_wdata[1:0] == 2'b11) |=> bus_rdata[1:0] == 2'b01);
    // R9
    view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        icache_state == ((bus_rdata[1:0] == 2'b10) ? 2'b00 : bus_rdata[1:0]));
endmodule

bind cache_ctl_reg cache_ctl_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack),
    .icache_state(icache_state), .dcache_state(dcache_state)
);

// File: tb/cache_ctl_reg_bench.sv
// Directed bench for cache_ctl_reg.
module cache_ctl_reg_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq_ack = 0;
    logic [1:0]  icache_state, dcache_state;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cache_ctl_reg u_cache_ctl_reg (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on negedge, result visible after next posedge; sample at following negedge
    task automatic cyc(logic we, logic [31:0] d, logic ack);
        @(negedge clk); bus_we = we; bus_wdata = d; irq_ack = ack;
        @(negedge clk); bus_we = 0; irq_ack = 0;
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        chk("R1", bus_rdata, 0);
        chk("R1", {30'd0, icache_state}, 0);
        chk("R1", {30'd0, dcache_state}, 0);
    endtask

    task automatic t_write;
        cyc(1, 32'hFFFF_FF2D, 0);
        chk("R2", bus_rdata, 32'h2D);
        chk("R3", {28'd0, dcache_state, icache_state}, 32'hD);
    endtask

    task automatic t_ifreeze;
        cyc(1, 32'h1F, 0); cyc(0, 0, 1);
        chk("R4", bus_rdata, 32'h1D);
    endtask

    task automatic t_dfreeze;
        cyc(1, 32'h2F, 0); cyc(0, 0, 1);
        chk("R5", bus_rdata, 32'h27);
        cyc(1, 32'h3F, 0); cyc(0, 0, 1);
        chk("R5", bus_rdata, 32'h35);
    endtask

    task automatic t_noeffect;
        cyc(1, 32'h0F, 0); cyc(0, 0, 1);
        chk("R6", bus_rdata, 32'h0F);
        cyc(1, 32'h39, 0); cyc(0, 0, 1);
        chk("R6", bus_rdata, 32'h39);
        cyc(1, 32'h32, 0); cyc(0, 0, 1);
        chk("R6", bus_rdata, 32'h32);
        chk("R7", {26'd0, bus_rdata[5:0]} >> 4, 32'h3);
    endtask

    task automatic t_same;
        cyc(1, 32'h00, 0);
        cyc(1, 32'h3F, 1);
        chk("R8", bus_rdata, 32'h35);
        cyc(1, 32'h0F, 1);
        chk("R8", bus_rdata, 32'h0F);
    endtask

    task automatic t_view;
        cyc(1, 32'h0A, 0);
        chk("R9", bus_rdata, 32'h0A);
        chk("R9", {28'd0, dcache_state, icache_state}, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_write;
        t_ifreeze;
        t_dfreeze;
        t_noeffect;
        t_same;
        t_view;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule